// File: doc/BRIEF.md
# PHY Indirect Test-Register Port

This block is the receive end of a narrow, two-phase configuration channel that loads the timing and PLL settings of a serial display PHY. Software drives four signals from memory-mapped control words: a clear, a strobe, an address/data select flag and an 8-bit payload. Address and data share the payload bus. A falling strobe edge with the select flag high captures an address. A falling strobe edge with the flag low writes the payload into the entry at the most recently captured address.

The entries form a small register file. The clock lane has a set of timing entries. Each data lane has its own set. Three configuration bytes hold the transmit clock select and two packed PLL words. The fields of the PLL words are decoded onto dedicated outputs. A read port always returns the captured address and the contents of the entry at that address, so every write can be confirmed through the same channel.

Top module: `phy_tst_port`

## Requirements
- R1: After reset, and after a clear, every entry holds its default: 0xFF in every wakeup entry (the saturated maximum), 0x80 in the second PLL word, and 0x00 in every other entry. After reset or a clear the captured address is 0x00 and `addr_vld_o` is 0.
- R2: A strobe falling edge (`tst_strobe_i` 1 then 0 on consecutive clocks) with `tst_en_i`=1 captures `tst_din_i` as the address. The clock after that edge, `rd_addr_o` shows the new address and `addr_vld_o` is 1.
- R3: A strobe falling edge with `tst_en_i`=0, taken while a valid address is held, writes `tst_din_i` into that entry. `rd_data_o` shows the new value one clock later.
- R4: A data phase that comes before any address phase since the last reset or clear is ignored. No entry changes.
- R5: While the strobe is held high, or when it rises, nothing is captured or written. Writes happen only on the falling edge.
- R6: Address map: the clock lane uses 0x00 to 0x04 (LPX, HS-prepare, HS-zero, HS-trail, wakeup). Data lane L (0..NUM_LANES-1) uses 0x10*(L+1)+0 to +6 (LPX, HS-prepare, HS-zero, HS-trail, TA-go, TA-get, wakeup). 0x70 is the transmit clock select, 0x71 is PLL word A and 0x72 is PLL word B. Each entry is written independently of the others.
- R7: A write to an address outside the map is dropped, and reading such an address returns 0x00.
- R8: Fields of PLL word A: bit 5 drives `pll_div5_o`, bit 4 drives `pll_div1_o`, bits 3:1 drive `pll_fb_o` and bit 0 drives `pll_bw_en_o`.
- R9: Fields of PLL word B: bit 7 drives `pll_prediv_byp_o` and bits 6:0 drive `pll_prediv_o`.
- R10: While `tst_clr_i` is 1, every entry is held at its default and any strobe edge is ignored.
- R11: Several data phases after one address phase all write the same entry. The last one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tst_clr_i | input | 1 | Clear; while high, all entries are held at their defaults |
| tst_strobe_i | input | 1 | Phase strobe; acts on its falling edge |
| tst_en_i | input | 1 | 1 = payload is an address, 0 = payload is data |
| tst_din_i | input | 8 | Shared address/data payload |
| rd_addr_o | output | 8 | Most recently captured address |
| rd_data_o | output | 8 | Contents of the entry at `rd_addr_o` |
| addr_vld_o | output | 1 | An address has been captured since the last reset or clear |
| pll_div5_o | output | 1 | PLL word A, divide-by-5 select |
| pll_div1_o | output | 1 | PLL word A, divide-by-1 select |
| pll_fb_o | output | 3 | PLL word A, feedback field |
| pll_bw_en_o | output | 1 | PLL word A, bandwidth enable |
| pll_prediv_byp_o | output | 1 | PLL word B, pre-divider bypass |
| pll_prediv_o | output | 7 | PLL word B, pre-divide value |

## Verification
The strobe is sampled on each rising clock edge, so a falling edge is seen on the first clock that samples it low. The captured address, the written value and the decoded PLL fields all appear just after that same clock. The bench drives inputs on falling clock edges. It lowers the strobe, waits one full clock, and only then queues the expected result. The monitor compares the result 1 ns after the next rising edge, and no input changes until the monitor has sampled. The hold-high case queues its expectations while the strobe is still high, so a write that was taken too early shows up as a mismatch.

// File: rtl/phy_tst_pkg.sv
`timescale 1ns/1ps
package phy_tst_pkg;
  localparam int unsigned TST_DW       = 8;
  localparam int unsigned CLK_ENTRIES  = 5;
  localparam int unsigned LANE_ENTRIES = 7;
  localparam int unsigned CFG_ENTRIES  = 3;
  localparam int unsigned CLK_BASE     = 'h00;
  localparam int unsigned LANE_STRIDE  = 'h10;
  localparam int unsigned CFG_BASE     = 'h70;
  localparam int unsigned CLK_WAKE     = 4;
  localparam int unsigned LANE_WAKE    = 6;
  localparam int unsigned CFG_PLL_A    = 1;
  localparam int unsigned CFG_PLL_B    = 2;
  localparam logic [TST_DW-1:0] WAKE_DEF  = 8'hFF;
  localparam logic [TST_DW-1:0] PLL_B_DEF = 8'h80;
endpackage

// File: rtl/phy_tst_phase.sv
`timescale 1ns/1ps
module phy_tst_phase #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          strobe_i,
  input  logic          en_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] addr_o,
  output logic          addr_vld_o,
  output logic          wr_o,
  output logic [DW-1:0] wdata_o
);
  logic          strobe_q;
  logic          fall;
  logic [DW-1:0] addr_q;
  logic          vld_q;

  assign fall = strobe_q & ~strobe_i & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      addr_q   <= '0;
      vld_q    <= 1'b0;
    end else begin
      strobe_q <= strobe_i;
      if (clr_i) begin
        addr_q <= '0;
        vld_q  <= 1'b0;
      end else if (fall && en_i) begin
        addr_q <= din_i;
        vld_q  <= 1'b1;
      end
    end
  end

  // data phase without a prior address phase is dropped
  assign wr_o       = fall & ~en_i & vld_q;
  assign wdata_o    = din_i;
  assign addr_o     = addr_q;
  assign addr_vld_o = vld_q;

  AST_WR_NEEDS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> addr_vld_o); // R4
  AST_CLR_DROPS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!addr_vld_o && addr_o == '0)); // R10
  AST_ADDR_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && strobe_q && !strobe_i) |=> (addr_vld_o && addr_o == $past(din_i))); // R2
endmodule

// File: rtl/phy_tst_regfile.sv
`timescale 1ns/1ps
module phy_tst_regfile import phy_tst_pkg::*; #(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned DW        = TST_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] pll_a_o,
  output logic [DW-1:0] pll_b_o
);
  logic [DW-1:0] clk_q  [CLK_ENTRIES];
  logic [DW-1:0] lane_q [NUM_LANES][LANE_ENTRIES];
  logic [DW-1:0] cfg_q  [CFG_ENTRIES];

  for (genvar i = 0; i < CLK_ENTRIES; i++) begin : g_clk
    localparam logic [DW-1:0] DEF = (i == CLK_WAKE) ? DW'(WAKE_DEF) : '0;
    localparam logic [DW-1:0] ADR = DW'(CLK_BASE + i);
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    q <= DEF;
      else if (clr_i)                 q <= DEF;
      else if (we_i && addr_i == ADR) q <= wdata_i;
    end
    assign clk_q[i] = q;
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    for (genvar e = 0; e < LANE_ENTRIES; e++) begin : g_ent
      localparam logic [DW-1:0] DEF = (e == LANE_WAKE) ? DW'(WAKE_DEF) : '0;
      localparam logic [DW-1:0] ADR = DW'(LANE_STRIDE * (l + 1) + e);
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    q <= DEF;
        else if (clr_i)                 q <= DEF;
        else if (we_i && addr_i == ADR) q <= wdata_i;
      end
      assign lane_q[l][e] = q;
    end
  end

  for (genvar c = 0; c < CFG_ENTRIES; c++) begin : g_cfg
    localparam logic [DW-1:0] DEF = (c == CFG_PLL_B) ? DW'(PLL_B_DEF) : '0;
    localparam logic [DW-1:0] ADR = DW'(CFG_BASE + c);
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    q <= DEF;
      else if (clr_i)                 q <= DEF;
      else if (we_i && addr_i == ADR) q <= wdata_i;
    end
    assign cfg_q[c] = q;
  end

  // unmapped addresses read as zero
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < CLK_ENTRIES; i++)
      if (addr_i == DW'(CLK_BASE + i)) rd_data_o = clk_q[i];
    for (int l = 0; l < NUM_LANES; l++)
      for (int e = 0; e < LANE_ENTRIES; e++)
        if (addr_i == DW'(LANE_STRIDE * (l + 1) + e)) rd_data_o = lane_q[l][e];
    for (int c = 0; c < CFG_ENTRIES; c++)
      if (addr_i == DW'(CFG_BASE + c)) rd_data_o = cfg_q[c];
  end

  assign pll_a_o = cfg_q[CFG_PLL_A];
  assign pll_b_o = cfg_q[CFG_PLL_B];

  AST_CLR_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (clk_q[CLK_WAKE] == DW'(WAKE_DEF) && pll_b_o == DW'(PLL_B_DEF) && pll_a_o == '0)); // R1
  AST_IDLE_HOLDS_PLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !clr_i) |=> ($stable(pll_a_o) && $stable(pll_b_o))); // R3
endmodule

// File: rtl/phy_tst_port.sv
`timescale 1ns/1ps
module phy_tst_port import phy_tst_pkg::*; #(
  parameter int unsigned NUM_LANES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tst_clr_i,
  input  logic              tst_strobe_i,
  input  logic              tst_en_i,
  input  logic [TST_DW-1:0] tst_din_i,
  output logic [TST_DW-1:0] rd_addr_o,
  output logic [TST_DW-1:0] rd_data_o,
  output logic              addr_vld_o,
  output logic              pll_div5_o,
  output logic              pll_div1_o,
  output logic [2:0]        pll_fb_o,
  output logic              pll_bw_en_o,
  output logic              pll_prediv_byp_o,
  output logic [6:0]        pll_prediv_o
);
  logic              wr;
  logic [TST_DW-1:0] wdata;
  logic [TST_DW-1:0] pll_a;
  logic [TST_DW-1:0] pll_b;

  phy_tst_phase #(.DW(TST_DW)) i_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (tst_clr_i),
    .strobe_i   (tst_strobe_i),
    .en_i       (tst_en_i),
    .din_i      (tst_din_i),
    .addr_o     (rd_addr_o),
    .addr_vld_o (addr_vld_o),
    .wr_o       (wr),
    .wdata_o    (wdata)
  );

  phy_tst_regfile #(.NUM_LANES(NUM_LANES), .DW(TST_DW)) i_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (tst_clr_i),
    .we_i      (wr),
    .addr_i    (rd_addr_o),
    .wdata_i   (wdata),
    .rd_data_o (rd_data_o),
    .pll_a_o   (pll_a),
    .pll_b_o   (pll_b)
  );

  assign pll_div5_o       = pll_a[5];
  assign pll_div1_o       = pll_a[4];
  assign pll_fb_o         = pll_a[3:1];
  assign pll_bw_en_o      = pll_a[0];
  assign pll_prediv_byp_o = pll_b[7];
  assign pll_prediv_o     = pll_b[6:0];

  AST_STROBE_HIGH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tst_clr_i && tst_strobe_i) |=> ($stable(rd_data_o) && $stable(rd_addr_o))); // R5
endmodule

// File: tb/test_phy_tst_port.sv
`timescale 1ns/1ps
module test_phy_tst_port;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr = 1'b0, stb = 1'b0, en = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] rd_addr, rd_data;
  logic       vld, div5, div1, bw, byp;
  logic [2:0] fb;
  logic [6:0] prediv;

  always #2 clk = ~clk;

  phy_tst_port #(.NUM_LANES(4)) i_phy_tst_port (
    .clk_i(clk), .rst_ni(rst_ni), .tst_clr_i(clr), .tst_strobe_i(stb),
    .tst_en_i(en), .tst_din_i(din), .rd_addr_o(rd_addr), .rd_data_o(rd_data),
    .addr_vld_o(vld), .pll_div5_o(div5), .pll_div1_o(div1), .pll_fb_o(fb),
    .pll_bw_en_o(bw), .pll_prediv_byp_o(byp), .pll_prediv_o(prediv)
  );

  typedef struct packed {
    logic [7:0]  addr;
    logic [7:0]  data;
    logic        vld;
    logic        chk_pll;
    logic [13:0] pll;
  } exp_t;

  exp_t       exp_q[$];
  string      tag_q[$];
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;
  logic [7:0] model [256];
  logic [7:0] cur_addr = '0;
  logic       cur_vld = 1'b0;

  function automatic bit mapped(logic [7:0] a);
    if (a <= 8'h04) return 1;
    if (a[7:4] >= 1 && a[7:4] <= 4 && a[3:0] <= 6) return 1;
    if (a >= 8'h70 && a <= 8'h72) return 1;
    return 0;
  endfunction

  function automatic logic [7:0] dflt(logic [7:0] a);
    if (a == 8'h04) return 8'hFF;
    if (a[7:4] >= 1 && a[7:4] <= 4 && a[3:0] == 6) return 8'hFF;
    if (a == 8'h72) return 8'h80;
    return 8'h00;
  endfunction

  task automatic model_defaults();
    for (int a = 0; a < 256; a++) model[a] = dflt(8'(a));
    cur_addr = '0;
    cur_vld  = 1'b0;
  endtask

  task automatic push(string tag, logic cp);
    exp_t e;
    logic [7:0] a, b;
    a = model[8'h71];
    b = model[8'h72];
    e.addr    = cur_addr;
    e.data    = model[cur_addr];
    e.vld     = cur_vld;
    e.chk_pll = cp;
    e.pll     = {a[5], a[4], a[3:1], a[0], b[7], b[6:0]};
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic phase(logic en_v, logic [7:0] v);
    @(negedge clk);
    en = en_v; din = v; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_addr(logic [7:0] a);
    phase(1'b1, a);
    cur_addr = a;
    cur_vld  = 1'b1;
  endtask

  task automatic wr_data(logic [7:0] v);
    phase(1'b0, v);
    if (cur_vld && mapped(cur_addr)) model[cur_addr] = v;
  endtask

  // monitor: compare queued expectations after each rising edge
  always @(posedge clk) begin
    exp_t  e;
    string t;
    logic [13:0] act;
    #1;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      act = {div5, div1, fb, bw, byp, prediv};
      n_chk++;
      if (rd_addr !== e.addr || rd_data !== e.data || vld !== e.vld ||
          (e.chk_pll && act !== e.pll)) begin
        n_fail++;
        $display("FAIL %s: addr=%h data=%h vld=%b pll=%h expected addr=%h data=%h vld=%b pll=%h",
                 t, rd_addr, rd_data, vld, act, e.addr, e.data, e.vld, e.pll);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_defaults();
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    push("R1 reset defaults", 1'b1);

    // R4: data before any address
    wr_data(8'h5A);
    push("R4 early data dropped", 1'b0);
    wr_addr(8'h00);
    push("R4 entry 0 untouched", 1'b0);

    // R2 / R3 / R11
    wr_addr(8'h04);
    push("R2 address captured, wakeup default R1", 1'b0);
    wr_data(8'h3C);
    push("R3 data written", 1'b0);
    wr_data(8'h11);
    wr_data(8'h22);
    push("R11 last data wins", 1'b0);

    // R5: strobe held high
    @(negedge clk);
    en = 1'b0; din = 8'h77; stb = 1'b1;
    @(negedge clk);
    push("R5 strobe high no write", 1'b0);
    @(negedge clk);
    push("R5 strobe still high", 1'b0);
    @(negedge clk);
    stb = 1'b0;
    @(negedge clk);
    model[cur_addr] = 8'h77;
    push("R5 write on falling edge", 1'b0);

    // R8 / R9: PLL field decode
    wr_addr(8'h71);
    wr_data(8'h2B);
    push("R8 pll word A 0x2B", 1'b1);
    wr_data(8'h1C);
    push("R8 pll word A 0x1C", 1'b1);
    wr_addr(8'h72);
    wr_data(8'h05);
    push("R9 pll word B 0x05", 1'b1);
    wr_data(8'hFF);
    push("R9 pll word B 0xFF", 1'b1);

    // R6 / R7: full address sweep
    for (int a = 0; a < 256; a++) begin
      wr_addr(8'(a));
      wr_data(8'(a) ^ 8'hA5);
      push(mapped(8'(a)) ? "R6 sweep write" : "R7 unmapped write", 1'b0);
    end
    for (int a = 0; a < 256; a++) begin
      wr_addr(8'(a));
      push(mapped(8'(a)) ? "R6 readback independent" : "R7 unmapped reads zero", 1'b0);
    end

    // R10: clear with a strobe edge inside it
    @(negedge clk);
    clr = 1'b1; en = 1'b1; din = 8'h40; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
    model_defaults();
    push("R10 clear restores defaults", 1'b1);
    wr_data(8'h99);
    push("R10 data after clear dropped R4", 1'b0);
    wr_addr(8'h46);
    push("R10 lane wakeup default R1", 1'b0);
    wr_addr(8'h72);
    push("R10 pll word B default R1", 1'b1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule